// File: doc/BRIEF.md
# Programmable Periodic Down-Counter Timer

This block is a down-counting timer core with a 64-bit count and a 64-bit reload limit. The count falls by one on every tick. The tick interval is a programmed number of clock cycles plus a 32-bit binary fraction. The fraction is summed into a phase register, and every carry out of that sum adds one clock cycle to the current tick. This keeps the long-run tick rate exact even when the clock does not divide evenly into it.

The timer runs in one of three states: off, periodic or one-shot. In periodic state, the tick that takes the count down from one (or from zero) pulses the expiry output for one cycle and reloads the count from the limit. In one-shot state, that tick pulses the expiry output, leaves the count at zero and switches the timer off.

A parent block drives the timer through a single command port that carries an opcode, a 64-bit data word and a reload flag. The commands set the limit, write the count, set the tick period, set the tick rate as a frequency, start the timer in either state, and stop it. The current count and the run state can be read at any time.

Top module: `pdown_timer`

## Requirements
- R1: After reset the count reads 0, the expiry output is low and runMode reads 0 (off). The run-state encoding is 0 off, 1 periodic, 2 one-shot.
- R2: Opcode 0 (set limit) stores cmdData as the limit. When cmdReload is 1, the count also becomes the new limit at the same edge. When cmdReload is 0, the count does not change.
- R3: In periodic state (opcode 4 starts it), each tick lowers the count by one. The tick that finds the count at 1 or 0 raises expire for one cycle and loads the count from the limit.
- R4: In one-shot state (opcode 5 starts it), the tick that finds the count at 1 or 0 raises expire for one cycle, leaves the count at 0 and returns runMode to 0. No later expiry follows.
- R5: Opcode 2 (set period) takes the low 32 bits of cmdData as the whole number of clock cycles per tick and clears the fraction. The first tick comes that many edges after the start edge.
- R6: Opcode 3 (set frequency) takes a nonzero low 32-bit word f. The whole period becomes BASE_HZ/f and the fraction becomes the low 32 bits of (BASE_HZ<<32)/f. A carry from the phase sum makes the current tick one cycle longer. A value of f = 0 is ignored.
- R7: A set-limit, set-period or set-frequency command while the timer runs discards the partial tick. The next tick then comes one full interval after that command's edge.
- R8: Opcode 1 (set count) loads cmdData into the count without touching the tick timing. While the timer runs, the next tick decrements the new value.
- R9: Opcode 4 while the limit is 0 is ignored, so the timer stays off and no expiry is raised.
- R10: Opcode 6 (stop) sets runMode to 0, holds the count and drops any partial tick. After a restart, the first tick takes a full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdOp | input | 3 | Command opcode (0 limit, 1 count, 2 period, 3 frequency, 4 run periodic, 5 run one-shot, 6 stop) |
| cmdReload | input | 1 | With opcode 0, also load the count from the new limit |
| cmdData | input | 64 | Command operand |
| count | output | 64 | Current count |
| expire | output | 1 | One-cycle expiry pulse |
| runMode | output | 2 | Run state: 0 off, 1 periodic, 2 one-shot |

## Verification
The bench checks the main counting function against a table of period, limit and mode combinations, and each row reads back the count, the number of expiries and the run state:

- A short periodic run separates the plain decrement from the reload.
- A run with a period of one and a limit of two forces back-to-back expiries.
- One-shot rows separate stopping on expiry from reloading.

Directed tests cover the following, each placing its checks at the cycle where a faulty design would differ:

- a fractional rate, where a tick pattern of 2,3,2,3 cycles must differ from a plain period of two;
- a period rewrite in the middle of a tick, set against an unrestarted prescaler;
- a count write while running, set against a restart;
- stop and restart, set against a prescaler that keeps its partial progress;
- a periodic start with a zero limit.

// File: rtl/pdt_pkg.sv
package pdt_pkg;

  typedef enum logic [2:0] {
    OP_SET_LIMIT    = 3'd0,
    OP_SET_COUNT    = 3'd1,
    OP_SET_PERIOD   = 3'd2,
    OP_SET_FREQ     = 3'd3,
    OP_RUN_PERIODIC = 3'd4,
    OP_RUN_ONESHOT  = 3'd5,
    OP_STOP         = 3'd6
  } cmdOpE;

  typedef enum logic [1:0] {
    RS_OFF      = 2'd0,
    RS_PERIODIC = 2'd1,
    RS_ONESHOT  = 2'd2
  } runStateE;

  // strobes from control to the count/limit datapath
  typedef struct packed {
    logic ldLimit;
    logic ldCount;
    logic decCount;
    logic reloadCount;
    logic zeroCount;
  } dpStrobesT;

endpackage

// File: rtl/pdt_datapath.sv
module pdt_datapath
  import pdt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobesT        strobes,
  input  logic [CNT_W-1:0] dataIn,
  output logic [CNT_W-1:0] countQ,
  output logic [CNT_W-1:0] limitQ,
  output logic             countLow,
  output logic             limitZero
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ <= '0;
      countQ <= '0;
    end else begin
      if (strobes.ldLimit) limitQ <= dataIn;
      if (strobes.ldCount)          countQ <= dataIn;
      else if (strobes.reloadCount) countQ <= limitQ;
      else if (strobes.zeroCount)   countQ <= '0;
      else if (strobes.decCount)    countQ <= countQ - 1'b1;
    end
  end

  // count of 0 or 1: the next tick is the expiring one
  assign countLow  = (countQ[CNT_W-1:1] == '0);
  assign limitZero = (limitQ == '0);

endmodule

// File: rtl/pdt_ctrl.sv
module pdt_ctrl
  import pdt_pkg::*;
#(
  parameter int          PER_W   = 32,
  parameter int          FRAC_W  = 32,
  parameter int          FREQ_W  = 32,
  parameter int unsigned BASE_HZ = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic              cmdReload,
  input  logic [PER_W-1:0]  periodIn,
  input  logic [FREQ_W-1:0] freqIn,
  input  logic              dataZero,
  input  logic              countLow,
  input  logic              limitZero,
  output dpStrobesT         strobes,
  output logic              expire,
  output logic [1:0]        runMode
);

  localparam int QW = PER_W + FRAC_W;
  localparam int LW = PER_W + 1;
  localparam logic [QW-1:0] NUMER = QW'(BASE_HZ) << FRAC_W;

  runStateE          state, stateD;
  logic [PER_W-1:0]  periodQ;
  logic [FRAC_W-1:0] fracQ;
  logic [FRAC_W-1:0] phaseQ;
  logic [LW-1:0]     prescQ;

  // command decode
  logic isLimit, isCount, isPeriod, isFreq, isRunP, isRunO, isStop, restart;
  assign isLimit  = cmdValid && (cmdOp == OP_SET_LIMIT);
  assign isCount  = cmdValid && (cmdOp == OP_SET_COUNT);
  assign isPeriod = cmdValid && (cmdOp == OP_SET_PERIOD);
  assign isFreq   = cmdValid && (cmdOp == OP_SET_FREQ) && (freqIn != '0);
  assign isRunP   = cmdValid && (cmdOp == OP_RUN_PERIODIC);
  assign isRunO   = cmdValid && (cmdOp == OP_RUN_ONESHOT);
  assign isStop   = cmdValid && (cmdOp == OP_STOP);
  assign restart  = isLimit || isPeriod || isFreq;

  // frequency to period/fraction conversion
  logic [QW-1:0] divisor, quot;
  assign divisor = (freqIn == '0) ? QW'(1) : QW'(freqIn);
  assign quot    = NUMER / divisor;

  // fractional prescaler: a phase carry lengthens the current tick
  logic [FRAC_W:0] phaseSum;
  logic [LW-1:0]   tickLen;
  logic            running, atEnd, tick, effTick;
  assign phaseSum = {1'b0, phaseQ} + {1'b0, fracQ};
  assign tickLen  = {1'b0, periodQ} + LW'(phaseSum[FRAC_W]);
  assign running  = (state != RS_OFF);
  assign atEnd    = running && (tickLen != '0) && (prescQ == tickLen - 1'b1);
  assign tick     = atEnd && !restart && !isStop;
  assign effTick  = tick && !isCount;

  always_comb begin
    strobes.ldLimit     = isLimit;
    strobes.ldCount     = isCount || (isLimit && cmdReload);
    strobes.decCount    = effTick && !countLow;
    strobes.reloadCount = effTick && countLow && (state == RS_PERIODIC);
    strobes.zeroCount   = effTick && countLow && (state == RS_ONESHOT);
  end

  always_comb begin
    stateD = state;
    if (strobes.zeroCount) stateD = RS_OFF;
    if (isRunP && !limitZero) stateD = RS_PERIODIC;
    if (isRunO) stateD = RS_ONESHOT;
    if (isStop) stateD = RS_OFF;
    if (isLimit && dataZero && state == RS_PERIODIC) stateD = RS_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RS_OFF;
      periodQ <= PER_W'(1);
      fracQ   <= '0;
      phaseQ  <= '0;
      prescQ  <= '0;
      expire  <= 1'b0;
    end else begin
      state  <= stateD;
      expire <= effTick && countLow;
      if (isPeriod) begin
        periodQ <= periodIn;
        fracQ   <= '0;
      end else if (isFreq) begin
        periodQ <= quot[QW-1:FRAC_W];
        fracQ   <= quot[FRAC_W-1:0];
      end
      if (restart || isStop || !running) begin
        prescQ <= '0;
        phaseQ <= '0;
      end else if (atEnd) begin
        prescQ <= '0;
        phaseQ <= phaseSum[FRAC_W-1:0];
      end else begin
        prescQ <= prescQ + 1'b1;
      end
    end
  end

  assign runMode = state;

endmodule

// File: rtl/pdown_timer.sv
module pdown_timer
  import pdt_pkg::*;
#(
  parameter int          CNT_W   = 64,
  parameter int          PER_W   = 32,
  parameter int          FRAC_W  = 32,
  parameter int          FREQ_W  = 32,
  parameter int unsigned BASE_HZ = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic             cmdReload,
  input  logic [CNT_W-1:0] cmdData,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic [1:0]       runMode
);

  dpStrobesT        strobes;
  logic [CNT_W-1:0] limitQ;
  logic             countLow, limitZero;

  pdt_ctrl #(
    .PER_W(PER_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W), .BASE_HZ(BASE_HZ)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdReload (cmdReload),
    .periodIn  (cmdData[PER_W-1:0]),
    .freqIn    (cmdData[FREQ_W-1:0]),
    .dataZero  (cmdData == '0),
    .countLow  (countLow),
    .limitZero (limitZero),
    .strobes   (strobes),
    .expire    (expire),
    .runMode   (runMode)
  );

  pdt_datapath #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dataIn    (cmdData),
    .countQ    (count),
    .limitQ    (limitQ),
    .countLow  (countLow),
    .limitZero (limitZero)
  );

endmodule

// File: rtl/pdown_timer_chk.sv
module pdown_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [2:0]       cmdOp,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] limitQ,
  input logic             expire,
  input logic [1:0]       runMode
);

  // R3: a periodic expiry comes with the count reloaded from the limit
  a_r3_reload_on_expire: assert property (@(posedge clk) disable iff (!rstN)
    (expire && $past(runMode) == 2'd1 && !$past(cmdValid)) |-> (count == limitQ));

  // R4: a one-shot expiry leaves the count at zero and the timer off
  a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rstN)
    (expire && $past(runMode) == 2'd2 && !$past(cmdValid)) |-> (count == '0 && runMode == 2'd0));

  // R3: no expiry unless the timer was running
  a_r3_expire_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> ($past(runMode) != 2'd0));

  // R9: periodic start with zero limit keeps the timer off
  a_r9_zero_limit_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (runMode == 2'd0 && cmdValid && cmdOp == 3'd4 && limitQ == '0) |=> (runMode == 2'd0));

  // R10: an idle, stopped timer holds its count
  a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (runMode == 2'd0 && !cmdValid) |=> $stable(count));

  // R1: run state never takes the unused encoding
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    runMode != 2'd3);

endmodule

bind pdown_timer pdown_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .count    (count),
  .limitQ   (limitQ),
  .expire   (expire),
  .runMode  (runMode)
);

// File: tb/sim_pdown_timer.sv
module sim_pdown_timer;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic [31:0] per;
    logic [63:0] lim;
    logic        oneShot;
    logic [15:0] waitN;
    logic [63:0] expCount;
    logic [7:0]  expExp;
    logic [1:0]  expMode;
  } vecT;

  // period, limit, one-shot, edges waited, count, expiries, mode
  localparam vecT VECS [NVEC] = '{
    '{32'd1, 64'd5,  1'b0, 16'd3,  64'd2, 8'd0, 2'd1},
    '{32'd1, 64'd5,  1'b0, 16'd5,  64'd5, 8'd1, 2'd1},
    '{32'd3, 64'd4,  1'b0, 16'd20, 64'd2, 8'd1, 2'd1},
    '{32'd2, 64'd3,  1'b1, 16'd10, 64'd0, 8'd1, 2'd0},
    '{32'd4, 64'd10, 1'b1, 16'd13, 64'd7, 8'd0, 2'd2},
    '{32'd1, 64'd2,  1'b0, 16'd7,  64'd1, 8'd3, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic        cmdReload = 1'b0;
  logic [63:0] cmdData = 64'd0;
  logic [63:0] count;
  logic        expire;
  logic [1:0]  runMode;

  int totalCnt = 0;
  int failCnt = 0;
  int expSeen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdown_timer u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdReload(cmdReload), .cmdData(cmdData),
    .count(count), .expire(expire), .runMode(runMode)
  );

  always @(posedge clk) if (rstN && expire) expSeen++;

  function automatic int expNow();
    return expSeen + int'(expire);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [63:0] data, input logic rl);
    @(negedge clk);
    cmdValid  = 1'b1;
    cmdOp     = op;
    cmdData   = data;
    cmdReload = rl;
    @(negedge clk);
    cmdValid  = 1'b0;
    cmdReload = 1'b0;
  endtask

  // stop, set period, load limit into count, start; returns half a cycle after the start edge
  task automatic setupRun(input logic [31:0] per, input logic [63:0] lim, input logic os);
    doCmd(3'd6, 64'd0, 1'b0);
    doCmd(3'd2, {32'd0, per}, 1'b0);
    doCmd(3'd0, lim, 1'b1);
    doCmd(os ? 3'd5 : 3'd4, 64'd0, 1'b0);
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 count", count, 64'd0);
    check("R1 expire", {63'd0, expire}, 64'd0);
    check("R1 runMode", {62'd0, runMode}, 64'd0);

    // table walk: R3 periodic, R4 one-shot, R5 integer period
    for (int i = 0; i < NVEC; i++) begin
      doCmd(3'd6, 64'd0, 1'b0);
      base = expNow();
      setupRun(VECS[i].per, VECS[i].lim, VECS[i].oneShot);
      repeat (int'(VECS[i].waitN)) @(posedge clk);
      @(negedge clk);
      check(VECS[i].oneShot ? "R4 vec count" : "R3 R5 vec count", count, VECS[i].expCount);
      check(VECS[i].oneShot ? "R4 vec expiries" : "R3 vec expiries",
            64'(expNow() - base), {56'd0, VECS[i].expExp});
      check(VECS[i].oneShot ? "R4 vec mode" : "R3 vec mode", {62'd0, runMode}, {62'd0, VECS[i].expMode});
    end

    // R2: limit without reload leaves count, later reload uses new limit
    doCmd(3'd6, 64'd0, 1'b0);
    doCmd(3'd2, 64'd1, 1'b0);
    doCmd(3'd0, 64'd9, 1'b1);
    doCmd(3'd0, 64'd33, 1'b0);
    check("R2 no reload keeps count", count, 64'd9);
    base = expNow();
    doCmd(3'd4, 64'd0, 1'b0);
    repeat (9) @(posedge clk);
    @(negedge clk);
    check("R2 R3 reload from new limit", count, 64'd33);
    check("R3 single expiry", 64'(expNow() - base), 64'd1);

    // R6: 1000/400 = 2.5 cycles per tick -> ticks at +2,+5,+7,+10
    doCmd(3'd6, 64'd0, 1'b0);
    doCmd(3'd3, 64'd400, 1'b0);
    doCmd(3'd0, 64'd100, 1'b1);
    doCmd(3'd4, 64'd0, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R6 fractional rate", count, 64'd96);

    // R9: periodic start with zero limit
    doCmd(3'd6, 64'd0, 1'b0);
    doCmd(3'd2, 64'd1, 1'b0);
    doCmd(3'd0, 64'd0, 1'b1);
    base = expNow();
    doCmd(3'd4, 64'd0, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R9 stays off", {62'd0, runMode}, 64'd0);
    check("R9 count", count, 64'd0);
    check("R9 no expiry", 64'(expNow() - base), 64'd0);

    // R7: period rewrite mid-tick restarts the interval
    setupRun(32'd4, 64'd50, 1'b0);
    repeat (2) @(posedge clk);
    doCmd(3'd2, 64'd4, 1'b0);
    check("R7 after rewrite", count, 64'd50);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 no early tick", count, 64'd50);
    @(posedge clk);
    @(negedge clk);
    check("R7 tick after full interval", count, 64'd49);

    // R8: count write while running keeps tick timing
    setupRun(32'd4, 64'd50, 1'b0);
    doCmd(3'd1, 64'd20, 1'b0);
    check("R8 count written", count, 64'd20);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R8 next tick decrements new value", count, 64'd19);

    // R10: stop holds and drops partial tick
    setupRun(32'd4, 64'd50, 1'b0);
    repeat (6) @(posedge clk);
    doCmd(3'd6, 64'd0, 1'b0);
    check("R10 count held", count, 64'd49);
    check("R10 mode off", {62'd0, runMode}, 64'd0);
    doCmd(3'd4, 64'd0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 partial tick lost", count, 64'd49);
    @(posedge clk);
    @(negedge clk);
    check("R10 full interval after restart", count, 64'd48);

    done = 1'b1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

endmodule